// File: doc/BRIEF.md
# Byte-Wide Configuration Host Controller

This block is the host side of a byte-wide slave configuration port. It pulls configuration bytes from an upstream valid/ready stream and drives them onto an 8-bit bus toward the target device. It produces the configuration clock from the system clock through a programmable divider, sequences the chip select and write strobe, and holds each byte on the bus for as long as the target reports busy. Each byte is bit-reversed on the way out, so the leftmost (most significant) bit of every file byte reaches data line 0.

A byte marked last closes the session. Chip select drops first, then write, and completion is reported once the target's done input is high. The same port can also run a readback session. Write stays low, chip select goes high, and a requested number of bytes is captured, one per configuration clock rise. Each captured byte is reversed back into file order and handed out as a one-cycle pulse.

Top module: `cfg_byte_host`

## Requirements
- R1: After reset chip select, write, the configuration clock and `done_o` are low, `s_ready_o` is high, and `mode_o` is constantly 3'b110 (bit 0 = M0 = 0, bit 1 = M1 = 1, bit 2 = M2 = 1). The configuration clock is low whenever chip select is low.
- R2: Every upstream byte is transferred exactly once, in stream order, on a configuration clock rise at which chip select and write are high and `busy_i` is low.
- R3: Bit i of an upstream byte is driven on `d_o[7-i]`.
- R4: A clock rise that sees `busy_i` high does not consume the byte. The byte on `d_o` stays unchanged while chip select, write and `busy_i` are all high.
- R5: `s_ready_o` is high only while `busy_i` is low and the holding register is empty.
- R6: The configuration clock's high and low phases each last `div_i`+1 system clock cycles while bytes are flowing. With `div_i`=0 one byte moves every two system cycles.
- R7: Write rises only while chip select is low. Write never changes in a cycle that follows one with chip select and the configuration clock both high.
- R8: After the last byte, chip select falls while the configuration clock is low, and write falls one cycle later. `done_o` stays low until `done_i` is high and then rises.
- R9: A readback request with nonzero `rb_len_i` runs a session with write low and chip select high. It captures `rb_len_i` bytes from `d_i`, one per clock rise. Each is presented on `rb_data_o` bit-reversed (`d_i[7-i]` to bit i) with a one-cycle `rb_valid_o`.
- R10: A readback request with `rb_len_i`=0 is ignored: chip select stays low and no byte is captured.
- R11: If a readback request and an upstream byte arrive in the same idle cycle, the readback runs first and `s_ready_o` is low in that cycle. The byte is written in a later session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Configuration clock half-period minus one, in system cycles |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | DATA_W | Upstream byte in file bit order |
| s_last_i | input | 1 | Marks the final byte of a session |
| s_ready_o | output | 1 | Upstream byte accepted when high with valid |
| rb_start_i | input | 1 | Readback request, honoured in idle |
| rb_len_i | input | LEN_W | Number of bytes to read back |
| rb_valid_o | output | 1 | One-cycle pulse with a readback byte |
| rb_data_o | output | DATA_W | Readback byte in file bit order |
| done_o | output | 1 | Session complete, cleared by the next session |
| mode_o | output | 3 | Mode pin levels for the target |
| cclk_o | output | 1 | Configuration clock to the target |
| cs_o | output | 1 | Chip select, active high |
| wr_o | output | 1 | Write strobe, high for writing |
| d_o | output | DATA_W | Bus data toward the target |
| d_oe_o | output | 1 | Bus output enable |
| d_i | input | DATA_W | Bus data from the target during readback |
| busy_i | input | 1 | Target flow-control flag |
| done_i | input | 1 | Target's configuration-complete flag |

## Verification
Two things can land on the same idle cycle: a readback request and an upstream byte offer. The bench raises both on one cycle. It checks that ready is low in that very cycle, that the readback bytes come out first, and that the pending byte is written afterwards. A second collision comes from the modelled target. It raises busy after a byte has been loaded but before the next clock rise, so a rise and busy meet. The bench counts the refused rises, checks that the bus byte does not move while busy is high, and confirms that the received stream has no gap or duplicate.

// File: rtl/cfgh_pkg.sv
`timescale 1ns/1ps
package cfgh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SELECT = 3'd1,
        ST_WRITE  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_READ   = 3'd4,
        ST_FINISH = 3'd5
    } cfgh_state_e;

    typedef enum logic [1:0] {
        FIN_CS   = 2'd0,
        FIN_WR   = 2'd1,
        FIN_DONE = 2'd2
    } cfgh_fin_e;

    // mode pin levels: bit0 = M0, bit1 = M1, bit2 = M2
    localparam logic [2:0] CFGH_MODE_BYTE = 3'b110;

endpackage

// File: rtl/cfgh_bitrev.sv
`timescale 1ns/1ps
module cfgh_bitrev #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    for (genvar gi = 0; gi < W; gi++) begin : g_swap
        assign out_o[gi] = in_i[W-1-gi];
    end
endmodule

// File: rtl/cfgh_clkgen.sv
`timescale 1ns/1ps
module cfgh_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             cclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             cclk_d, cclk_q;
    logic             phase_end;

    assign phase_end = (cnt_q >= half_i);

    always_comb begin
        cnt_d  = cnt_q;
        cclk_d = cclk_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!en_i) begin
            cnt_d  = '0;
            cclk_d = 1'b0;
        end else if (cclk_q) begin
            if (phase_end) begin
                cclk_d = 1'b0;
                cnt_d  = '0;
                fall_o = 1'b1;
            end else begin
                cnt_d = cnt_q + DIV_W'(1);
            end
        end else begin
            if (phase_end) begin
                if (run_i) begin
                    cclk_d = 1'b1;
                    cnt_d  = '0;
                    rise_o = 1'b1;
                end
            end else begin
                cnt_d = cnt_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            cclk_q <= cclk_d;
        end
    end

    assign cclk_o = cclk_q;

    // R6
    rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_q) |-> $past(run_i));

    // R6
    en_low_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !cclk_q);

endmodule

// File: rtl/cfg_byte_host.sv
`timescale 1ns/1ps
module cfg_byte_host
    import cfgh_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    input  logic              rb_start_i,
    input  logic [LEN_W-1:0]  rb_len_i,
    output logic              rb_valid_o,
    output logic [DATA_W-1:0] rb_data_o,
    output logic              done_o,
    output logic [2:0]        mode_o,
    output logic              cclk_o,
    output logic              cs_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] d_o,
    output logic              d_oe_o,
    input  logic [DATA_W-1:0] d_i,
    input  logic              busy_i,
    input  logic              done_i
);

    typedef struct packed {
        cfgh_state_e       state;
        cfgh_fin_e         step;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              last;
        logic              cs;
        logic              wr;
        logic              rd;
        logic [LEN_W-1:0]  cnt;
        logic [DATA_W-1:0] rb_data;
        logic              rb_valid;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] tx_rev;
    logic [DATA_W-1:0] rx_rev;
    logic              clk_en, clk_run;
    logic              rise, fall;
    logic              rb_go;
    logic              ready;
    logic              load;

    cfgh_bitrev #(.W(DATA_W)) u_tx_rev (
        .in_i  (s_data_i),
        .out_o (tx_rev)
    );

    cfgh_bitrev #(.W(DATA_W)) u_rx_rev (
        .in_i  (d_i),
        .out_o (rx_rev)
    );

    assign clk_en  = (r_q.state == ST_WRITE) || (r_q.state == ST_HOLD) ||
                     (r_q.state == ST_READ)  || (r_q.state == ST_FINISH);
    assign clk_run = (((r_q.state == ST_WRITE) || (r_q.state == ST_HOLD)) && r_q.full) ||
                     ((r_q.state == ST_READ) && (r_q.cnt != '0));

    cfgh_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .run_i  (clk_run),
        .half_i (div_i),
        .cclk_o (cclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign rb_go = rb_start_i && (rb_len_i != '0);

    always_comb begin
        ready = 1'b0;
        unique case (r_q.state)
            ST_IDLE:   ready = !rb_go;
            ST_SELECT: ready = !r_q.rd;
            ST_WRITE,
            ST_HOLD:   ready = 1'b1;
            default:   ready = 1'b0;
        endcase
        ready = ready && !r_q.full && !busy_i;
    end

    assign load = s_valid_i && ready;

    always_comb begin
        r_d          = r_q;
        r_d.rb_valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.full) begin
                    r_d.state = ST_SELECT;
                    r_d.wr    = 1'b1;
                    r_d.rd    = 1'b0;
                    r_d.done  = 1'b0;
                end else if (rb_go) begin
                    r_d.state = ST_SELECT;
                    r_d.wr    = 1'b0;
                    r_d.rd    = 1'b1;
                    r_d.cnt   = rb_len_i;
                    r_d.done  = 1'b0;
                end
            end
            ST_SELECT: begin
                r_d.cs    = 1'b1;
                r_d.state = r_q.rd ? ST_READ : ST_WRITE;
            end
            ST_WRITE, ST_HOLD: begin
                if (rise) begin
                    if (busy_i) begin
                        r_d.state = ST_HOLD;
                    end else begin
                        r_d.full  = 1'b0;
                        r_d.step  = FIN_CS;
                        r_d.state = r_q.last ? ST_FINISH : ST_WRITE;
                    end
                end
            end
            ST_READ: begin
                if (rise) begin
                    r_d.rb_data  = rx_rev;
                    r_d.rb_valid = 1'b1;
                    r_d.cnt      = r_q.cnt - LEN_W'(1);
                    if (r_q.cnt == LEN_W'(1)) begin
                        r_d.state = ST_FINISH;
                        r_d.step  = FIN_CS;
                    end
                end
            end
            ST_FINISH: begin
                unique case (r_q.step)
                    FIN_CS: begin
                        if (!cclk_o) begin
                            r_d.cs   = 1'b0;
                            r_d.step = FIN_WR;
                        end
                    end
                    FIN_WR: begin
                        r_d.wr   = 1'b0;
                        r_d.step = FIN_DONE;
                    end
                    default: begin
                        if (done_i) begin
                            r_d.done  = 1'b1;
                            r_d.rd    = 1'b0;
                            r_d.state = ST_IDLE;
                        end
                    end
                endcase
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (load) begin
            r_d.data = tx_rev;
            r_d.full = 1'b1;
            r_d.last = s_last_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign s_ready_o  = ready;
    assign rb_valid_o = r_q.rb_valid;
    assign rb_data_o  = r_q.rb_data;
    assign done_o     = r_q.done;
    assign mode_o     = CFGH_MODE_BYTE;
    assign cs_o       = r_q.cs;
    assign wr_o       = r_q.wr;
    assign d_o        = r_q.data;
    assign d_oe_o     = r_q.wr;

    // R1
    clock_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> !cclk_o);

    // R4
    hold_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && wr_o && busy_i) |=> $stable(d_o));

    // R5
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !busy_i);

    // R7
    wr_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_o) |-> !cs_o);

    // R7
    wr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && cclk_o) |=> $stable(wr_o));

    // R8
    cs_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> !cclk_o);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cs_o && !wr_o));

    // R9
    rb_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid_o |-> (cs_o && !wr_o));

endmodule

// File: tb/tb_cfg_byte_host.sv
`timescale 1ns/1ps
module tb_cfg_byte_host;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div = 8'd2;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       rb_start = 1'b0;
    logic [15:0] rb_len = 16'd0;
    logic       rb_valid;
    logic [7:0] rb_data;
    logic       done;
    logic [2:0] mode;
    logic       cclk, cs, wr, d_oe;
    logic [7:0] d_out;
    logic [7:0] d_in = 8'h00;
    logic       busy = 1'b0;
    logic       done_in = 1'b0;

    always #10 clk = ~clk;

    cfg_byte_host dut (
        .clk(clk), .rst_n(rst_n), .div_i(div),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
        .rb_start_i(rb_start), .rb_len_i(rb_len), .rb_valid_o(rb_valid), .rb_data_o(rb_data),
        .done_o(done), .mode_o(mode), .cclk_o(cclk), .cs_o(cs), .wr_o(wr),
        .d_o(d_out), .d_oe_o(d_oe), .d_i(d_in), .busy_i(busy), .done_i(done_in)
    );

    int tests = 0;
    int fails = 0;

    // data[12:5], stall[4:1], last[0]
    localparam logic [12:0] VEC [8] = '{
        {8'hA5, 4'd0, 1'b0}, {8'h01, 4'd2, 1'b0}, {8'h80, 4'd0, 1'b0}, {8'h3C, 4'd5, 1'b0},
        {8'hFF, 4'd1, 1'b0}, {8'h00, 4'd0, 1'b0}, {8'h96, 4'd3, 1'b0}, {8'hC3, 4'd0, 1'b1}
    };

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = v[7-i];
        return o;
    endfunction

    function automatic logic [7:0] rb_pat(input int i);
        return 8'((i * 53) ^ 8'hC6);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    // target model, evaluated at every falling system edge
    logic [7:0] rx [64];
    int         rx_cyc [64];
    logic [7:0] rb_got [64];
    int         rb_cyc [64];
    int         stall_of [64];
    int rx_n = 0, rb_n = 0, cyc = 0;
    int rdy_err = 0, order_err = 0, hold_err = 0, stall_rises = 0, rbwr_err = 0;
    int busy_wait = 0, busy_len = 0, rb_idx = 0;
    int prev_rise = -1, min_sp = 9999, max_sp = 0;
    logic meas_clr = 1'b0;
    logic cclk_prev = 1'b0, wr_prev = 1'b0;
    logic [7:0] hold_val = 8'h00;

    initial for (int i = 0; i < 64; i++) stall_of[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic rising;
            cyc++;
            rising = cclk && !cclk_prev;
            cclk_prev = cclk;
            if (s_ready && busy) rdy_err++;
            if (wr && !wr_prev && cs) order_err++;
            wr_prev = wr;
            if (busy && cs && wr && d_out != hold_val) hold_err++;
            if (rb_valid) begin
                if (wr) rbwr_err++;
                rb_got[rb_n % 64] = rb_data;
                rb_cyc[rb_n % 64] = cyc;
                rb_n++;
            end
            if (meas_clr) begin
                prev_rise = -1; min_sp = 9999; max_sp = 0;
            end
            if (rb_start) begin
                rb_idx = 0;
                d_in = rb_pat(0);
            end
            if (rising) begin
                if (prev_rise >= 0) begin
                    if (cyc - prev_rise < min_sp) min_sp = cyc - prev_rise;
                    if (cyc - prev_rise > max_sp) max_sp = cyc - prev_rise;
                end
                prev_rise = cyc;
                if (cs && wr) begin
                    if (busy) stall_rises++;
                    else begin
                        rx[rx_n % 64] = d_out;
                        rx_cyc[rx_n % 64] = cyc;
                        busy_wait = 2;
                        busy_len = stall_of[rx_n % 64] * 4;
                        rx_n++;
                    end
                end else if (cs && !wr) begin
                    rb_idx++;
                    d_in = rb_pat(rb_idx);
                end
            end
            if (busy_wait > 0) begin
                busy_wait--;
                if (busy_wait == 0 && busy_len > 0) begin
                    busy = 1'b1;
                    hold_val = d_out;
                end
            end else if (busy_len > 0) begin
                busy_len--;
                if (busy_len == 0) busy = 1'b0;
            end
        end
    end

    task automatic send(input logic [7:0] d, input logic l, output logic first_rdy);
        logic rdy;
        bit   first = 1'b1;
        s_valid = 1'b1; s_data = d; s_last = l;
        do begin
            #1;
            rdy = s_ready;
            if (first) first_rdy = rdy;
            first = 1'b0;
            step();
        end while (!rdy);
        s_valid = 1'b0;
    endtask

    task automatic clear_meas();
        meas_clr = 1'b1;
        step();
        meas_clr = 1'b0;
    endtask

    task automatic wait_cs(input logic lvl);
        while (cs !== lvl) step();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic fr;
        int base, rbase;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(cs == 0 && wr == 0 && cclk == 0 && done == 0, "R1 reset outputs", {cs, wr, cclk, done}, 0);
        chk(s_ready == 1, "R1 ready after reset", s_ready, 1);
        chk(mode == 3'b110, "R1 mode pins", mode, 3'b110);

        // vector table: div 2, with busy stalls
        div = 8'd2;
        done_in = 1'b0;
        for (int k = 0; k < 8; k++) stall_of[k] = int'(VEC[k][4:1]);
        clear_meas();
        base = rx_n;
        for (int k = 0; k < 8; k++) send(VEC[k][12:5], VEC[k][0], fr);
        wait_cs(1'b0);
        chk(wr == 1 && cclk == 0, "R8 cs drops first with clock low", {wr, cclk}, 2'b10);
        step();
        chk(wr == 0, "R8 write drops next cycle", wr, 0);
        chk(rx_n - base == 8, "R2 byte count", rx_n - base, 8);
        for (int k = 0; k < 8; k++)
            chk(rx[(base + k) % 64] == rev8(VEC[k][12:5]), "R3 reversed byte on bus",
                rx[(base + k) % 64], rev8(VEC[k][12:5]));
        chk(stall_rises > 0, "R4 busy met a clock rise", stall_rises, 1);
        chk(hold_err == 0, "R4 bus held while busy", hold_err, 0);
        chk(min_sp == 6, "R6 period at div 2", min_sp, 6);
        repeat (5) step();
        chk(done == 0, "R8 done waits for target", done, 0);
        done_in = 1'b1;
        step(); step();
        chk(done == 1, "R8 done after target done", done, 1);

        // fastest divider, no stalls
        div = 8'd0;
        for (int k = 0; k < 64; k++) stall_of[k] = 0;
        base = rx_n;
        clear_meas();
        send(8'h5A, 1'b0, fr);
        send(8'hE1, 1'b0, fr);
        send(8'h0F, 1'b0, fr);
        send(8'h77, 1'b1, fr);
        wait_cs(1'b0);
        step(); step();
        chk(min_sp == 2 && max_sp == 2, "R6 two cycles per byte at div 0", max_sp, 2);
        chk(rx_n - base == 4 && rx[(base + 3) % 64] == rev8(8'h77), "R2 fast stream order",
            rx[(base + 3) % 64], rev8(8'h77));
        chk(rx[(base + 1) % 64] == rev8(8'hE1), "R3 fast stream reversal",
            rx[(base + 1) % 64], rev8(8'hE1));

        // readback of four bytes
        div = 8'd1;
        rbase = rb_n;
        rb_len = 16'd4;
        rb_start = 1'b1;
        step();
        rb_start = 1'b0;
        wait_cs(1'b1);
        wait_cs(1'b0);
        step(); step();
        chk(rb_n - rbase == 4, "R9 readback count", rb_n - rbase, 4);
        for (int k = 0; k < 4; k++)
            chk(rb_got[(rbase + k) % 64] == rev8(rb_pat(k)), "R9 readback byte",
                rb_got[(rbase + k) % 64], rev8(rb_pat(k)));
        chk(rbwr_err == 0 && done == 1, "R9 write low during readback", rbwr_err, 0);

        // zero-length readback request
        rbase = rb_n;
        rb_len = 16'd0;
        rb_start = 1'b1;
        step();
        rb_start = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 20; k++) begin
                if (cs) seen++;
                step();
            end
            chk(seen == 0 && rb_n == rbase, "R10 zero length ignored", seen, 0);
        end

        // readback and upstream byte on the same idle cycle
        rbase = rb_n;
        base = rx_n;
        rb_len = 16'd2;
        fork
            send(8'h6B, 1'b1, fr);
            begin
                rb_start = 1'b1;
                step();
                rb_start = 1'b0;
            end
        join
        chk(fr == 0, "R11 ready low on collision cycle", fr, 0);
        wait_cs(1'b1);
        wait_cs(1'b0);
        step(); step();
        chk(rb_n - rbase == 2 && rx_n - base == 1, "R11 both sessions ran",
            (rb_n - rbase) * 16 + (rx_n - base), 8'h21);
        chk(rb_cyc[rbase % 64] < rx_cyc[base % 64], "R11 readback first",
            rb_cyc[rbase % 64], rx_cyc[base % 64]);
        chk(rx[base % 64] == rev8(8'h6B), "R11 deferred byte", rx[base % 64], rev8(8'h6B));

        chk(rdy_err == 0, "R5 ready never with busy", rdy_err, 0);
        chk(order_err == 0, "R7 write rises before select", order_err, 0);
        chk(cs == 0 && cclk == 0, "R1 clock quiet when idle", {cs, cclk}, 0);

        summary();
        $finish;
    end

endmodule